// File: doc/BRIEF.md
# Multi-channel threshold trigger detector

This block watches several streams of raw signed ADC samples, one per channel, all on the sampling clock. For each channel it compares the sample with a programmable signed threshold in a chosen direction. A per-channel glitch filter then requires the over-threshold condition to persist before it is accepted. The rising edge of the filtered condition becomes a one-cycle channel pulse. The pulses of the enabled channels are merged by logical OR into one registered internal trigger, which is gated by a global enable.

Samples enter as a stream qualified by `in_valid`. The block never applies back-pressure, so it has no ready signal. Every clock edge with `in_valid` high consumes one sample per channel, and edges with `in_valid` low leave the filter state unchanged. Configuration is held as static register-style inputs. A debug bus shows either the raw samples or, in test mode, the internal stages of channel 0.

Top module: `thresh_trigger_detector`

## Requirements
- R1: With polarity 0 (rising), a channel is over threshold when its sample, read as two's complement, is greater than or equal to its threshold, also read as two's complement.
- R2: With polarity 1 (falling), a channel is over threshold when its signed sample is less than or equal to its signed threshold.
- R3: For a filter length L, the filtered flag takes the raw flag's new value only after the raw flag has differed from the filtered flag on L+1 consecutive valid samples. A shorter excursion leaves the filtered flag unchanged.
- R4: With L = 0, the filtered flag equals the raw flag of the previous valid sample, which is a one-register delay.
- R5: A channel produces a single one-cycle pulse when its filtered flag goes from 0 to 1. It produces no further pulse while the flag stays at 1.
- R6: A channel's pulse reaches `trig_out` only when both its enable bit and `int_trig_en` are 1.
- R7: `trig_out` is the OR of the enabled channel pulses, registered, so it is high in the cycle after the pulse.
- R8: Synchronous reset clears all filter counters, filtered flags and edge history. `trig_out` is 0 during reset and in the first cycle after it.
- R9: A clock edge with `in_valid` low does not advance any filter counter and does not change any filtered flag.
- R10: With `test_mode` = 1, the debug lanes 0 to 3 (each SW bits wide, lane 0 in the least significant bits) carry the following. Lane 0 is the channel 0 sample. Lane 1 is the channel 0 raw flag. Lane 2 is the channel 0 filtered flag. Lane 3 is `trig_out`. Each flag sits in bit 0 of its lane, and the upper bits of that lane are zero.
- R11: With `test_mode` = 0, debug lane i carries the current sample of channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the samples on `in_samples` |
| in_samples | input | NCH*SW | Signed samples; channel i occupies bits [i*SW +: SW] |
| thresholds | input | NCH*SW | Signed per-channel thresholds, packed like the samples |
| polarity | input | NCH | Per-channel direction: 0 rising, 1 falling |
| filt_len | input | NCH*FW | Per-channel glitch filter length L |
| ch_enable | input | NCH | Per-channel trigger enable |
| int_trig_en | input | 1 | Global internal trigger enable |
| test_mode | input | 1 | Selects the debug view of the internal stages |
| trig_out | output | 1 | Combined internal trigger pulse |
| dbg_out | output | 4*SW | Debug lanes, as set out in R10 and R11 |

## Verification
Several properties are checked on every cycle. Filtered flags hold across invalid edges. A zero-length filter follows the raw flag after one register. A flag whose raw value agrees with it does not move. Channel pulses never last two cycles. The global enable silences the output, and the output is quiet after reset. Other behaviour can only be shown by the bench's scenarios against a cycle-level reference model. This covers rejection of excursions shorter than the filter length, the equality boundaries of both polarities, OR-merging when channels fire together, and the content of the debug lanes.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  localparam int DEF_NCH = 4;
  localparam int DEF_SW  = 16;
  localparam int DEF_FW  = 8;
  localparam int DBG_LANES = 4;

  typedef enum logic {
    POL_RISE = 1'b0,
    POL_FALL = 1'b1
  } pol_e;
endpackage

// File: rtl/mtt_compare.sv
module mtt_compare #(
  parameter int SW = 16
) (
  input  logic [SW-1:0] sample,
  input  logic [SW-1:0] thresh,
  input  logic          pol,
  output logic          over
);
  import mtt_pkg::*;

  logic signed [SW-1:0] s_sample;
  logic signed [SW-1:0] s_thresh;

  assign s_sample = sample;
  assign s_thresh = thresh;

  always_comb begin
    if (pol == POL_FALL) over = (s_sample <= s_thresh);
    else                 over = (s_sample >= s_thresh);
  end
endmodule

// File: rtl/mtt_glitch_filter.sv
module mtt_glitch_filter #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          raw,
  input  logic [FW-1:0] len,
  output logic          filt
);
  logic [FW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      filt <= 1'b0;
    end else if (valid) begin
      if (raw == filt) begin
        cnt <= '0;
      end else if (cnt >= len) begin
        filt <= raw;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_hold_on_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(filt));

  assert_zero_len_follow_R4: assert property (@(posedge clk) disable iff (rst)
    (valid && len == '0) |=> (filt == $past(raw)));

  assert_agree_no_move_R3: assert property (@(posedge clk) disable iff (rst)
    (valid && raw == filt) |=> $stable(filt));
endmodule

// File: rtl/mtt_edge.sv
module mtt_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level;
  end

  assign pulse = level & ~prev;

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/thresh_trigger_detector.sv
module thresh_trigger_detector #(
  parameter int NCH = mtt_pkg::DEF_NCH,
  parameter int SW  = mtt_pkg::DEF_SW,
  parameter int FW  = mtt_pkg::DEF_FW
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [NCH*SW-1:0]             in_samples,
  input  logic [NCH*SW-1:0]             thresholds,
  input  logic [NCH-1:0]                polarity,
  input  logic [NCH*FW-1:0]             filt_len,
  input  logic [NCH-1:0]                ch_enable,
  input  logic                          int_trig_en,
  input  logic                          test_mode,
  output logic                          trig_out,
  output logic [mtt_pkg::DBG_LANES*SW-1:0] dbg_out
);
  import mtt_pkg::*;

  localparam int DBG_W = DBG_LANES * SW;

  logic [NCH-1:0] raw_over;
  logic [NCH-1:0] filt_over;
  logic [NCH-1:0] ch_pulse;
  logic           trig_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    mtt_compare #(.SW(SW)) u_cmp (
      .sample (in_samples[c*SW +: SW]),
      .thresh (thresholds[c*SW +: SW]),
      .pol    (polarity[c]),
      .over   (raw_over[c])
    );

    mtt_glitch_filter #(.FW(FW)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .valid (in_valid),
      .raw   (raw_over[c]),
      .len   (filt_len[c*FW +: FW]),
      .filt  (filt_over[c])
    );

    mtt_edge u_edge (
      .clk   (clk),
      .rst   (rst),
      .level (filt_over[c]),
      .pulse (ch_pulse[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= int_trig_en & (|(ch_pulse & ch_enable));
  end

  assign trig_out = trig_q;

  logic [DBG_W-1:0] dbg_pass;
  logic [DBG_W-1:0] dbg_test;

  for (genvar l = 0; l < DBG_LANES; l++) begin : g_lane
    if (l < NCH) begin : g_src
      assign dbg_pass[l*SW +: SW] = in_samples[l*SW +: SW];
    end else begin : g_zero
      assign dbg_pass[l*SW +: SW] = '0;
    end
  end

  assign dbg_test[0*SW +: SW] = in_samples[0 +: SW];
  assign dbg_test[1*SW +: SW] = {{(SW-1){1'b0}}, raw_over[0]};
  assign dbg_test[2*SW +: SW] = {{(SW-1){1'b0}}, filt_over[0]};
  assign dbg_test[3*SW +: SW] = {{(SW-1){1'b0}}, trig_q};

  assign dbg_out = test_mode ? dbg_test : dbg_pass;

  assert_global_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !int_trig_en |=> !trig_out);

  assert_quiet_after_reset_R8: assert property (@(posedge clk)
    rst |=> !trig_out);

  assert_out_needs_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (ch_pulse & ch_enable) == '0 |=> !trig_out);
endmodule

// File: tb/thresh_trigger_detector_test.sv
`timescale 1ns/1ps
module thresh_trigger_detector_test;
  localparam int NCH = 4;
  localparam int SW  = 16;
  localparam int FW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NCH*SW-1:0] in_samples;
  logic [NCH*SW-1:0] thresholds;
  logic [NCH-1:0]    polarity;
  logic [NCH*FW-1:0] filt_len;
  logic [NCH-1:0]    ch_enable;
  logic              int_trig_en;
  logic              test_mode;
  logic              trig_out;
  logic [4*SW-1:0]   dbg_out;

  always #2.5 clk = ~clk;

  thresh_trigger_detector #(.NCH(NCH), .SW(SW), .FW(FW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_samples(in_samples),
    .thresholds(thresholds), .polarity(polarity), .filt_len(filt_len),
    .ch_enable(ch_enable), .int_trig_en(int_trig_en), .test_mode(test_mode),
    .trig_out(trig_out), .dbg_out(dbg_out)
  );

  logic signed [SW-1:0] c_thr [NCH];
  logic                 c_pol [NCH];
  logic [FW-1:0]        c_len [NCH];
  logic                 c_en  [NCH];
  logic signed [SW-1:0] n_smp [NCH];
  logic                 n_valid;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      thresholds[i*SW +: SW] = c_thr[i];
      polarity[i]            = c_pol[i];
      filt_len[i*FW +: FW]   = c_len[i];
      ch_enable[i]           = c_en[i];
    end
  end

  bit      m_filt [NCH];
  bit      m_prev [NCH];
  int      m_cnt  [NCH];
  bit      m_trig;
  int      n_checks = 0;
  int      n_fail   = 0;
  int      trig_seen = 0;
  bit      finished = 0;

  function automatic bit over_fn(logic signed [SW-1:0] s, logic signed [SW-1:0] t, bit pol);
    if (pol) return s <= t;
    return s >= t;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    bit any;
    bit raw;
    @(negedge clk);
    chk(trig_out == m_trig, "R5 R6 R7 trig_out", trig_out, m_trig);
    trig_seen += int'(trig_out);
    if (test_mode) begin
      chk(dbg_out[2*SW +: SW] == {15'd0, m_filt[0]}, "R3 R4 R9 R10 filtered lane",
          dbg_out[2*SW +: SW], m_filt[0]);
      chk(dbg_out[3*SW +: SW] == {15'd0, m_trig}, "R10 trigger lane",
          dbg_out[3*SW +: SW], m_trig);
    end
    in_valid = n_valid;
    for (int i = 0; i < NCH; i++) in_samples[i*SW +: SW] = n_smp[i];
    #1;
    if (test_mode) begin
      chk(dbg_out[0 +: SW] == n_smp[0], "R10 sample lane", dbg_out[0 +: SW], n_smp[0]);
      raw = over_fn(n_smp[0], c_thr[0], c_pol[0]);
      chk(dbg_out[SW +: SW] == {15'd0, raw}, "R1 R2 raw lane", dbg_out[SW +: SW], raw);
    end else begin
      for (int i = 0; i < NCH; i++)
        chk(dbg_out[i*SW +: SW] == n_smp[i], "R11 passthrough lane",
            dbg_out[i*SW +: SW], n_smp[i]);
    end
    any = 0;
    for (int i = 0; i < NCH; i++) begin
      if (m_filt[i] && !m_prev[i] && c_en[i]) any = 1;
      m_prev[i] = m_filt[i];
      if (n_valid) begin
        raw = over_fn(n_smp[i], c_thr[i], c_pol[i]);
        if (raw == m_filt[i]) m_cnt[i] = 0;
        else if (m_cnt[i] >= int'(c_len[i])) begin
          m_filt[i] = raw;
          m_cnt[i] = 0;
        end else m_cnt[i]++;
      end
    end
    m_trig = int_trig_en & any;
  endtask

  task automatic idle_cfg();
    for (int i = 0; i < NCH; i++) begin
      c_thr[i] = 16'sh7fff; c_pol[i] = 1'b0; c_len[i] = '0; c_en[i] = 1'b0;
      n_smp[i] = '0;
    end
    int_trig_en = 1'b1;
    test_mode = 1'b1;
    n_valid = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk(trig_out == 1'b0, "R8 trig_out during reset", trig_out, 0);
    rst = 1'b0;
    for (int i = 0; i < NCH; i++) begin m_filt[i] = 0; m_prev[i] = 0; m_cnt[i] = 0; end
    m_trig = 0;
    @(negedge clk);
    chk(trig_out == 1'b0, "R8 trig_out after reset", trig_out, 0);
    chk(dbg_out[2*SW +: SW] == '0 || !test_mode, "R8 filtered cleared",
        dbg_out[2*SW +: SW], 0);
  endtask

  task automatic run(int n, logic signed [SW-1:0] v0, logic signed [SW-1:0] v2);
    for (int k = 0; k < n; k++) begin
      n_smp[0] = v0; n_smp[2] = v2;
      step();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    in_samples = '0;
    idle_cfg();
    do_reset();

    c_thr[0] = 16'sd100; c_len[0] = 8'd2; c_en[0] = 1'b1;
    trig_seen = 0;
    run(2, 16'sd100, 16'sd0);
    run(1, 16'sd99, 16'sd0);
    run(4, 16'sd0, 16'sd0);
    chk(trig_seen == 0, "R3 short excursion rejected", trig_seen, 0);
    run(3, 16'sd100, 16'sd0);
    run(6, 16'sd200, 16'sd0);
    chk(trig_seen == 1, "R1 R5 single pulse at equality", trig_seen, 1);

    idle_cfg(); do_reset();
    c_thr[2] = -16'sd50; c_pol[2] = 1'b1; c_en[2] = 1'b1;
    trig_seen = 0;
    run(1, 16'sd0, -16'sd49);
    run(1, 16'sd0, -16'sd50);
    run(3, 16'sd0, -16'sd50);
    chk(trig_seen == 1, "R2 R4 falling equality trigger", trig_seen, 1);

    idle_cfg(); do_reset();
    c_thr[0] = 16'sd10; c_len[0] = 8'd1; c_en[0] = 1'b1;
    trig_seen = 0;
    n_smp[0] = 16'sd20; n_valid = 1'b1; step();
    n_valid = 1'b0; step(); step(); step();
    chk(trig_seen == 0, "R9 invalid edges do not advance", trig_seen, 0);
    n_valid = 1'b1; step(); step(); step();
    chk(trig_seen == 1, "R9 resumes on valid", trig_seen, 1);

    idle_cfg(); do_reset();
    int_trig_en = 1'b0;
    c_thr[0] = 16'sd5; c_en[0] = 1'b1;
    trig_seen = 0;
    run(5, 16'sd9, 16'sd0);
    chk(trig_seen == 0, "R6 global enable blocks", trig_seen, 0);

    idle_cfg(); do_reset();
    c_thr[0] = 16'sd5; c_en[0] = 1'b1;
    c_thr[2] = 16'sd5; c_en[2] = 1'b1;
    trig_seen = 0;
    run(5, 16'sd9, 16'sd9);
    chk(trig_seen == 1, "R7 simultaneous channels merge", trig_seen, 1);

    for (int ph = 0; ph < 8; ph++) begin
      idle_cfg();
      for (int i = 0; i < NCH; i++) begin
        c_thr[i] = SW'($urandom_range(0, 2000)) - 16'sd1000;
        c_pol[i] = 1'($urandom_range(0, 1));
        c_len[i] = ($urandom_range(0, 3) == 0) ? FW'($urandom_range(0, 12)) : FW'($urandom_range(0, 2));
        c_en[i]  = 1'($urandom_range(0, 1));
      end
      int_trig_en = ($urandom_range(0, 4) != 0);
      test_mode = 1'($urandom_range(0, 1));
      do_reset();
      for (int k = 0; k < 400; k++) begin
        for (int i = 0; i < NCH; i++) begin
          if ($urandom_range(0, 9) < 7)
            n_smp[i] = c_thr[i] + SW'($urandom_range(0, 8)) - 16'sd4;
          else
            n_smp[i] = SW'($urandom);
        end
        n_valid = ($urandom_range(0, 5) != 0);
        step();
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule